// File: doc/BRIEF.md
# Read-Allocate Four-Way Data Cache Controller

This block sits between a processor load/store port and a plain word-wide memory request port. It looks up each access in a four-way set-associative store of 32-byte lines (eight 32-bit words), indexed and tagged directly by the virtual address that comes with the request. Read hits are answered from the local arrays. A read miss picks a victim way, writes that line back to memory first when it is valid and dirty, and then refills it from memory.

Writes never allocate. Each write carries a per-access region attribute. With the attribute high, a hit updates only the cached line and marks it dirty. With the attribute low, a hit updates both the line and memory. A write that misses goes straight to memory and leaves the arrays untouched. A static configuration input selects the replacement policy: a per-set round-robin pointer or a free-running pseudo-random sequence. Capacity is a parameter in kilobytes, and the number of sets follows from it.

Top module: `rdalloc_dcache`

## Requirements
- R1: After the synchronous active-low reset, every line is invalid and clean, every round-robin pointer is at way 0, and `cpu_ack` and `mem_req` are low. The first read of any address is therefore a miss.
- R2: A read hit returns the cached word. `cpu_ack` rises in the second cycle after `cpu_req` is first sampled high, and there is no memory traffic.
- R3: Address fields: bits [4:2] select the word in the line, the next log2(sets) bits select the set (sets = CACHE_KB*8), and the remaining upper bits form the tag. A read miss fetches the whole line as eight memory reads at ascending word addresses, starting from the line base (word field zero).
- R4: A read miss completes early. `cpu_ack` rises in the cycle after the memory word at the requested offset is accepted, carrying that word, and the rest of the fill continues. A new request waits until the fill ends.
- R5: A write hit with `cpu_wb`=1 updates the cached word, marks the line dirty, issues no memory write, and acknowledges in the second cycle after the request is sampled.
- R6: A write hit with `cpu_wb`=0 updates the cached word and issues exactly one memory write of the same address and data.
- R7: A write miss issues exactly one memory write, performs no memory read, and allocates nothing, so a later read of that address misses.
- R8: When the chosen victim is valid and dirty, its eight words are written to memory at ascending addresses before the first fill read. A clean or invalid victim causes no memory write.
- R9: With `cfg_random`=0, the victim is the way named by the set's 2-bit pointer. The pointer advances by one, modulo 4, on every allocation into that set, whether or not the way held valid data.
- R10: With `cfg_random`=1, the victim is the low 2 bits of a 16-bit right-shifting Galois LFSR. It is seeded with 0xACE1 at reset, uses tap mask 0xB400 and steps every cycle, so it never reaches zero. Every read still returns the most recently written value for its address.
- R11: On the memory port, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack` is sampled high. `cpu_ack` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_random | input | 1 | Replacement policy: 1 = pseudo-random, 0 = round-robin |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wb | input | 1 | Region attribute: 1 = write-back, 0 = write-through |
| cpu_addr | input | 32 | Virtual byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the current word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Read hits and write-back write hits are due two cycles after the request is first sampled. The bench raises the request on a falling edge, counts falling edges until it sees the acknowledge, and expects a count of exactly two. For misses, the bench records how many memory reads it has accepted by the falling edge at which `cpu_ack` is first seen, and expects one more than the requested word offset. Counts and orderings of memory traffic are compared only after `mem_req` has stayed low for four cycles, so the fill tail and any writeback are complete before the log is read. All sampling happens on falling edges, away from the rising edge at which the design registers its outputs.

// File: rtl/rdc_pkg.sv
// Shared constants and state encoding for the read-allocate data cache.
// Assumes 32-bit words and addresses, 8-word lines and 4 ways.
package rdc_pkg;
    localparam int WAYS       = 4;
    localparam int WAY_W      = 2;
    localparam int LINE_WORDS = 8;
    localparam int WORD_SEL_W = 3;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = LINE_WORDS * DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EV_RD,
        ST_EV_WR,
        ST_FILL,
        ST_WMEM
    } cstate_e;

    // Number of sets for a capacity in kilobytes.
    function automatic int sets_for_kb(input int kb);
        return (kb * 1024) / (WAYS * LINE_BYTES);
    endfunction
endpackage

// File: rtl/rdc_tag_store.sv
// Tag array plus valid and dirty state, one column per way.
// Tags are inferred synchronous-read RAM. Valid and dirty bits are flops,
// so reset clears them. Assumes at most one allocation per cycle.
module rdc_tag_store
    import rdc_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int TAG_W = 22,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0][TAG_W-1:0]  tag_q,
    input  logic [SET_W-1:0]            chk_set,
    output logic [WAYS-1:0]             valid_o,
    output logic [WAYS-1:0]             dirty_o,
    input  logic                        alloc_en,
    input  logic [WAY_W-1:0]            alloc_way,
    input  logic [SET_W-1:0]            alloc_set,
    input  logic [TAG_W-1:0]            alloc_tag,
    input  logic                        mark_en,
    input  logic [WAY_W-1:0]            mark_way,
    input  logic [SET_W-1:0]            mark_set
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [TAG_W-1:0] tram [SETS];
        logic [SETS-1:0]  vld_q;
        logic [SETS-1:0]  drt_q;

        // Tag RAM: write on allocation, registered read every cycle.
        always_ff @(posedge clk) begin
            if (alloc_en && alloc_way == WAY_W'(g))
                tram[alloc_set] <= alloc_tag;
            tag_q[g] <= tram[rd_set];
        end

        // Valid and dirty bits: set valid and clean on fill, dirty on marked write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
            end else begin
                if (alloc_en && alloc_way == WAY_W'(g)) begin
                    vld_q[alloc_set] <= 1'b1;
                    drt_q[alloc_set] <= 1'b0;
                end
                if (mark_en && mark_way == WAY_W'(g))
                    drt_q[mark_set] <= 1'b1;
            end
        end

        assign valid_o[g] = vld_q[chk_set];
        assign dirty_o[g] = drt_q[chk_set];

        // R8
        dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mark_en && mark_way == WAY_W'(g) |-> vld_q[mark_set]);
    end
endmodule

// File: rtl/rdc_data_store.sv
// Line data array: one word-wide inferred RAM per way, addressed by
// {set, word}. All ways are read in parallel with a registered output,
// and one way is written per cycle.
module rdc_data_store
    import rdc_pkg::*;
#(
    parameter int SETS = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int DEPTH = SETS * LINE_WORDS
) (
    input  logic                          clk,
    input  logic [SET_W-1:0]              rd_set,
    input  logic [WORD_SEL_W-1:0]         rd_word,
    output logic [WAYS-1:0][DATA_W-1:0]   rd_q,
    input  logic                          wr_en,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [SET_W-1:0]              wr_set,
    input  logic [WORD_SEL_W-1:0]         wr_word,
    input  logic [DATA_W-1:0]             wr_data
);
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [DATA_W-1:0] dram [DEPTH];

        // Word RAM: selected-way write and registered read.
        always_ff @(posedge clk) begin
            if (wr_en && wr_way == WAY_W'(g))
                dram[{wr_set, wr_word}] <= wr_data;
            rd_q[g] <= dram[{rd_set, rd_word}];
        end
    end
endmodule

// File: rtl/rdc_victim_sel.sv
// Victim way choice: a per-set 2-bit round-robin pointer, or the low bits
// of a free-running 16-bit Galois LFSR. The pointer of a set advances
// on every allocation into that set.
module rdc_victim_sel
    import rdc_pkg::*;
#(
    parameter int          SETS      = 32,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    parameter logic [15:0] LFSR_TAPS = 16'hB400,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_random,
    input  logic [SET_W-1:0]  sel_set,
    input  logic              adv_en,
    input  logic [SET_W-1:0]  adv_set,
    output logic [WAY_W-1:0]  victim
);
    logic [SETS-1:0][WAY_W-1:0] rr_q;
    logic [15:0]                lfsr_q;

    // Round-robin pointers: step the allocated set's pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (adv_en)
            rr_q[adv_set] <= rr_q[adv_set] + WAY_W'(1);
    end

    // LFSR: shift right every cycle, folding in the tap mask on a one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= LFSR_SEED;
        else
            lfsr_q <= lfsr_q[0] ? ((lfsr_q >> 1) ^ LFSR_TAPS) : (lfsr_q >> 1);
    end

    assign victim = cfg_random ? lfsr_q[WAY_W-1:0] : rr_q[sel_set];

    // R10
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'd0);

    // R9
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> rr_q[$past(adv_set)] == WAY_W'($past(rr_q[adv_set]) + WAY_W'(1)));
endmodule

// File: rtl/rdalloc_dcache.sv
// Four-way set-associative data cache controller with read-only allocation.
// Sequences lookup, optional dirty-victim writeback, line fill and
// write-through or write-miss memory writes. Assumes word-aligned addresses,
// a requester that holds cpu_req until cpu_ack, and a memory that answers
// each held request with a one-cycle mem_ack.
module rdalloc_dcache
    import rdc_pkg::*;
#(
    parameter int CACHE_KB = 4,
    localparam int SETS  = sets_for_kb(CACHE_KB),
    localparam int SET_W = $clog2(SETS),
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_random,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_wb,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [WORD_SEL_W-1:0] LAST_WORD = WORD_SEL_W'(LINE_WORDS - 1);

    cstate_e               state_q;
    logic [ADDR_W-1:0]     req_addr_q;
    logic                  req_we_q;
    logic                  req_wb_q;
    logic [DATA_W-1:0]     req_wdata_q;
    logic [WORD_SEL_W-1:0] cnt_q;
    logic [WAY_W-1:0]      vict_q;
    logic                  ack_q;
    logic [DATA_W-1:0]     rdata_q;

    logic [SET_W-1:0]      req_set, cpu_set, rd_set;
    logic [TAG_W-1:0]      req_tag;
    logic [WORD_SEL_W-1:0] req_word, cpu_word, rd_word;

    logic [WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [WAYS-1:0]             valid_w, dirty_w, hit_vec;
    logic [WAYS-1:0][DATA_W-1:0] dq;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way, victim;

    logic                  dw_en;
    logic [WAY_W-1:0]      dw_way;
    logic [WORD_SEL_W-1:0] dw_word;
    logic [DATA_W-1:0]     dw_data;
    logic                  alloc_en, mark_en;

    assign req_set  = req_addr_q[OFF_W +: SET_W];
    assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
    assign req_word = req_addr_q[2 +: WORD_SEL_W];
    assign cpu_set  = cpu_addr[OFF_W +: SET_W];
    assign cpu_word = cpu_addr[2 +: WORD_SEL_W];

    // Array read address: the incoming request while idle, the held one after.
    always_comb begin
        rd_set  = (state_q == ST_IDLE) ? cpu_set : req_set;
        rd_word = (state_q == ST_IDLE) ? cpu_word :
                  (state_q == ST_EV_RD || state_q == ST_EV_WR) ? cnt_q : req_word;
    end

    rdc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (rd_set),
        .tag_q     (tag_q),
        .chk_set   (req_set),
        .valid_o   (valid_w),
        .dirty_o   (dirty_w),
        .alloc_en  (alloc_en),
        .alloc_way (vict_q),
        .alloc_set (req_set),
        .alloc_tag (req_tag),
        .mark_en   (mark_en),
        .mark_way  (hit_way),
        .mark_set  (req_set)
    );

    rdc_data_store #(.SETS(SETS)) u_data (
        .clk     (clk),
        .rd_set  (rd_set),
        .rd_word (rd_word),
        .rd_q    (dq),
        .wr_en   (dw_en),
        .wr_way  (dw_way),
        .wr_set  (req_set),
        .wr_word (dw_word),
        .wr_data (dw_data)
    );

    rdc_victim_sel #(.SETS(SETS)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_random (cfg_random),
        .sel_set    (req_set),
        .adv_en     (alloc_en),
        .adv_set    (req_set),
        .victim     (victim)
    );

    // Tag compare across the ways and encode of the hitting way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_w[w] && (tag_q[w] == req_tag);
            if (hit_vec[w])
                hit_way = WAY_W'(w);
        end
        hit = |hit_vec;
    end

    // Array write and memory port controls decoded from the state.
    always_comb begin
        dw_en     = 1'b0;
        dw_way    = hit_way;
        dw_word   = req_word;
        dw_data   = req_wdata_q;
        alloc_en  = 1'b0;
        mark_en   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr_q;
        mem_wdata = req_wdata_q;
        unique case (state_q)
            ST_LOOKUP: begin
                dw_en   = req_we_q && hit;
                mark_en = req_we_q && hit && req_wb_q;
            end
            ST_EV_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[vict_q], req_set, cnt_q, 2'b00};
                mem_wdata = dq[vict_q];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_set, cnt_q, 2'b00};
                dw_en    = mem_ack;
                dw_way   = vict_q;
                dw_word  = cnt_q;
                dw_data  = mem_rdata;
                alloc_en = mem_ack && (cnt_q == LAST_WORD);
            end
            ST_WMEM: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    // Controller sequencing, request capture and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wb_q    <= 1'b0;
            req_wdata_q <= '0;
            cnt_q       <= '0;
            vict_q      <= '0;
            ack_q       <= 1'b0;
            rdata_q     <= '0;
        end else begin
            ack_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req && !ack_q) begin
                        req_addr_q  <= cpu_addr;
                        req_we_q    <= cpu_we;
                        req_wb_q    <= cpu_wb;
                        req_wdata_q <= cpu_wdata;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    cnt_q <= '0;
                    if (hit && !req_we_q) begin
                        ack_q   <= 1'b1;
                        rdata_q <= dq[hit_way];
                        state_q <= ST_IDLE;
                    end else if (hit && req_wb_q) begin
                        ack_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (req_we_q) begin
                        state_q <= ST_WMEM;
                    end else begin
                        vict_q  <= victim;
                        state_q <= (valid_w[victim] && dirty_w[victim]) ? ST_EV_RD : ST_FILL;
                    end
                end
                ST_EV_RD: state_q <= ST_EV_WR;
                ST_EV_WR: begin
                    if (mem_ack) begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= (cnt_q == LAST_WORD) ? ST_FILL : ST_EV_RD;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        if (cnt_q == req_word) begin
                            ack_q   <= 1'b1;
                            rdata_q <= mem_rdata;
                        end
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_WORD)
                            state_q <= ST_IDLE;
                    end
                end
                ST_WMEM: begin
                    if (mem_ack) begin
                        ack_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdata_q;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FILL && mem_ack && cnt_q != LAST_WORD |=>
            mem_req && !mem_we && mem_addr == $past(mem_addr) + 32'd4);

    // R5
    wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOOKUP && hit && req_we_q && req_wb_q |=> !mem_req && cpu_ack);

    // R2
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOOKUP |-> $onehot0(hit_vec));
endmodule

// File: tb/rdalloc_dcache_bench.sv
module rdalloc_dcache_bench;
    localparam int KB  = 4;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_random;
    logic        cpu_req, cpu_we, cpu_wb;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        cpu_ack;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    rdalloc_dcache #(.CACHE_KB(KB)) u_rdalloc_dcache (
        .clk(clk), .rst_n(rst_n), .cfg_random(cfg_random),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wb(cpu_wb),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int vectors = 0;
    int miscompares = 0;
    int rd_cnt, wr_cnt, log_n;
    logic [31:0] log_addr [64];
    logic        log_we   [64];
    logic [31:0] mem  [2048];
    logic [31:0] gold [2048];

    function automatic logic [31:0] mk_addr(input int t, input int s, input int w);
        return {19'd0, 3'(t), 5'(s), 3'(w), 2'b00};
    endfunction

    function automatic int widx(input logic [31:0] a);
        return int'(a[12:2]);
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic clr_log();
        rd_cnt = 0; wr_cnt = 0; log_n = 0;
    endtask

    task automatic access(input bit we, input bit wb, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc, output int rd_at_ack);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_wb = wb; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ack);
        rd = cpu_rdata;
        rd_at_ack = rd_cnt;
        cpu_req = 1'b0;
        if (we) gold[widx(a)] = d;
    endtask

    task automatic settle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (mem_req) quiet = 0; else quiet++;
        end
    endtask

    // Memory responder: acknowledges each held request after LAT cycles.
    initial begin
        int wait_cnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n !== 1'b1) begin
                mem_ack = 1'b0; wait_cnt = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                wait_cnt++;
                if (wait_cnt >= LAT) begin
                    wait_cnt = 0;
                    mem_ack = 1'b1;
                    if (log_n < 64) begin
                        log_addr[log_n] = mem_addr;
                        log_we[log_n] = mem_we;
                        log_n++;
                    end
                    if (mem_we) begin
                        mem[widx(mem_addr)] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem[widx(mem_addr)];
                        rd_cnt++;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] rd, old;
        int cyc, rda;
        for (int i = 0; i < 2048; i++) begin
            mem[i]  = (i * 32'h0100_0193) ^ 32'h5A5A_0000;
            gold[i] = mem[i];
        end
        clr_log();
        rst_n = 1'b0; cfg_random = 1'b0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_wb = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cpu_ack after reset", {31'd0, cpu_ack}, 32'd0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

        // R3 / R4: miss fills with every requested offset, each in its own set.
        for (int w = 0; w < 8; w++) begin
            clr_log();
            access(1'b0, 1'b0, mk_addr(0, 2 + w, w), 32'd0, rd, cyc, rda);
            settle();
            if (w == 0) chk("R1 first read misses", rd_cnt, 32'd8);
            chk("R4 reads accepted at ack", rda, w + 1);
            chk("R4 early word data", rd, gold[widx(mk_addr(0, 2 + w, w))]);
            chk("R3 fill read count", rd_cnt, 32'd8);
            chk("R3 fill write count", wr_cnt, 32'd0);
            for (int k = 0; k < 8; k++) begin
                chk("R3 fill address order", log_addr[k], mk_addr(0, 2 + w, k));
                chk("R3 fill is read", {31'd0, log_we[k]}, 32'd0);
            end
        end

        // R2: hits on every word of a filled line.
        for (int w = 0; w < 8; w++) begin
            clr_log();
            access(1'b0, 1'b0, mk_addr(0, 2, w), 32'd0, rd, cyc, rda);
            settle();
            chk("R2 hit latency", cyc, 32'd2);
            chk("R2 hit data", rd, gold[widx(mk_addr(0, 2, w))]);
            chk("R2 hit traffic", rd_cnt + wr_cnt, 32'd0);
        end

        // R5: write-back write hit.
        old = mem[widx(mk_addr(0, 3, 3))];
        clr_log();
        access(1'b1, 1'b1, mk_addr(0, 3, 3), 32'hDEAD_0005, rd, cyc, rda);
        settle();
        chk("R5 wb hit latency", cyc, 32'd2);
        chk("R5 wb no memory write", wr_cnt, 32'd0);
        chk("R5 memory unchanged", mem[widx(mk_addr(0, 3, 3))], old);
        clr_log();
        access(1'b0, 1'b0, mk_addr(0, 3, 3), 32'd0, rd, cyc, rda);
        settle();
        chk("R5 line updated", rd, 32'hDEAD_0005);
        chk("R5 readback is hit", rd_cnt, 32'd0);

        // R6: write-through write hit.
        clr_log();
        access(1'b1, 1'b0, mk_addr(0, 4, 4), 32'hBEEF_0006, rd, cyc, rda);
        settle();
        chk("R6 one memory write", wr_cnt, 32'd1);
        chk("R6 write address", log_addr[0], mk_addr(0, 4, 4));
        chk("R6 memory updated", mem[widx(mk_addr(0, 4, 4))], 32'hBEEF_0006);
        clr_log();
        access(1'b0, 1'b0, mk_addr(0, 4, 4), 32'd0, rd, cyc, rda);
        settle();
        chk("R6 line updated", rd, 32'hBEEF_0006);
        chk("R6 readback is hit", rd_cnt, 32'd0);

        // R7: write miss, no allocation.
        clr_log();
        access(1'b1, 1'b1, mk_addr(5, 20, 1), 32'hF00D_0007, rd, cyc, rda);
        settle();
        chk("R7 one memory write", wr_cnt, 32'd1);
        chk("R7 no memory read", rd_cnt, 32'd0);
        chk("R7 memory updated", mem[widx(mk_addr(5, 20, 1))], 32'hF00D_0007);
        clr_log();
        access(1'b0, 1'b0, mk_addr(5, 20, 1), 32'd0, rd, cyc, rda);
        settle();
        chk("R7 later read misses", rd_cnt, 32'd8);
        chk("R7 later read data", rd, 32'hF00D_0007);

        // R9: round-robin order in a fresh set.
        for (int t = 0; t < 5; t++) begin
            access(1'b0, 1'b0, mk_addr(t, 12, 0), 32'd0, rd, cyc, rda);
            settle();
        end
        for (int t = 1; t < 5; t++) begin
            clr_log();
            access(1'b0, 1'b0, mk_addr(t, 12, 1), 32'd0, rd, cyc, rda);
            settle();
            chk("R9 survivor hits", rd_cnt, 32'd0);
            chk("R9 survivor data", rd, gold[widx(mk_addr(t, 12, 1))]);
        end
        clr_log();
        access(1'b0, 1'b0, mk_addr(0, 12, 1), 32'd0, rd, cyc, rda);
        settle();
        chk("R9 way0 line was evicted", rd_cnt, 32'd8);
        chk("R8 clean victim no writeback", wr_cnt, 32'd0);

        // R8: dirty victim writeback before fill.
        for (int t = 0; t < 4; t++) begin
            access(1'b0, 1'b0, mk_addr(t, 13, 0), 32'd0, rd, cyc, rda);
            settle();
        end
        access(1'b1, 1'b1, mk_addr(0, 13, 2), 32'hCAFE_0008, rd, cyc, rda);
        settle();
        clr_log();
        access(1'b0, 1'b0, mk_addr(4, 13, 0), 32'd0, rd, cyc, rda);
        settle();
        chk("R8 writeback count", wr_cnt, 32'd8);
        chk("R8 fill count", rd_cnt, 32'd8);
        for (int k = 0; k < 8; k++) begin
            chk("R8 writeback address order", log_addr[k], mk_addr(0, 13, k));
            chk("R8 writeback first", {31'd0, log_we[k]}, 32'd1);
            chk("R8 written word", mem[widx(mk_addr(0, 13, k))], gold[widx(mk_addr(0, 13, k))]);
        end
        chk("R8 fill follows", log_addr[8], mk_addr(4, 13, 0));
        chk("R8 dirty data reached memory", mem[widx(mk_addr(0, 13, 2))], 32'hCAFE_0008);
        chk("R8 new line data", rd, gold[widx(mk_addr(4, 13, 0))]);

        // R10: pseudo-random replacement sweep with mixed write policies.
        cfg_random = 1'b1;
        for (int i = 0; i < 400; i++) begin
            int t, s, w;
            bit we, wb;
            t  = (i * 7 + i / 3) % 8;
            s  = 24 + (i / 5) % 2;
            w  = (i * 3) % 8;
            we = (i % 3 == 1);
            wb = (i % 4 != 0);
            access(we, wb, mk_addr(t, s, w), 32'hC0DE_0000 + i, rd, cyc, rda);
            if (!we) chk("R10 coherent read", rd, gold[widx(mk_addr(t, s, w))]);
        end
        settle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule